// File: doc/BRIEF.md
# Register Rename Status Table

This block sits in the issue stage of an out-of-order floating-point pipeline. It holds sixteen architectural registers, the even-numbered F0 through F30, held at index k = 0..15 where index k is register F(2k). Each entry holds a committed 64-bit value and a 4-bit status tag naming the reservation station that will write the register next. A status of zero means no write is outstanding.

When an instruction issues, the block resolves its two source registers. Each comes back either as a ready value or as the tag of the station that will produce it, so register names are dropped at this point. In the same cycle, the issuing station's tag becomes the pending writer of the destination register. The block also watches the shared result bus. A register takes the broadcast data only when its status still names the broadcasting station. A result from a writer that has since been superseded is therefore discarded, which removes write-after-write and write-after-read name hazards.

Top module: `rename_table`

## Requirements
- R1: After reset every status tag is zero (blank) and register index k holds the value (k+1) * 64'h0001_0001_0001_0001.
- R2: A source whose register is blank returns src_pend=0, src_tag=0 and the stored value on src_val, combinationally in the same cycle, whether or not an issue is valid.
- R3: A source whose register is pending returns src_pend=1, the pending tag on src_tag, and zero on src_val.
- R4: A valid issue with a non-zero tag writes that tag into the destination's status, visible from the next cycle. It replaces any older pending tag.
- R5: A valid bus broadcast with a non-zero tag writes bus_data into every register whose status equals that tag, and those registers become blank in the next cycle.
- R6: A broadcast whose tag differs from a register's current status leaves that register's status and value unchanged.
- R7: If an issue targets a register in the same cycle that a matching broadcast would clear it, the register ends pending with the new issue tag.
- R8: If a source register's pending tag equals the tag of a valid broadcast in the same cycle, the source returns src_pend=0, src_tag=0 and bus_data as its value.
- R9: An issue or broadcast with tag zero, or with its valid input low, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_tag | input | 4 | Tag of the issuing station (1..15) |
| iss_dst | input | 4 | Destination register index |
| iss_src_a | input | 4 | First source register index |
| iss_src_b | input | 4 | Second source register index |
| bus_valid | input | 1 | Result bus carries a result |
| bus_tag | input | 4 | Tag of the producing station |
| bus_data | input | 64 | Result value |
| a_pend | output | 1 | First source is still pending |
| a_tag | output | 4 | Pending producer of first source, else 0 |
| a_val | output | 64 | Value of first source, else 0 |
| b_pend | output | 1 | Second source is still pending |
| b_tag | output | 4 | Pending producer of second source, else 0 |
| b_val | output | 64 | Value of second source, else 0 |

## Verification
The hardest cases to reach from the ports need a particular relation between tags at the moment a broadcast arrives. One is a stale broadcast that lands after its register was claimed again. The other is a broadcast that coincides with a new claim or with a read of the same register. Random stimulus alone rarely lines these up. The random phase therefore draws tags from a small pool and usually picks the broadcast tag from tags that are pending. Directed sequences then set up each collision on purpose, and the result is read back through the source ports afterwards.

// File: rtl/rename_pkg.sv
package rename_pkg;
  localparam int NREG = 16;
  localparam int DW   = 64;
  localparam int TW   = 4;
  localparam int IW   = $clog2(NREG);

  // Reset contents of register index idx.
  function automatic logic [DW-1:0] init_value(input int idx);
    logic [DW-1:0] unit;
    unit = '0;
    for (int s = 0; s < DW; s += 16) unit[s] = 1'b1;
    return unit * DW'(idx + 1);
  endfunction

  // A broadcast hits an entry when it is valid, non-blank and names the writer.
  function automatic logic tag_hit(input logic vld, input logic [TW-1:0] bus_t,
                                   input logic [TW-1:0] entry_t);
    return vld && (bus_t != '0) && (bus_t == entry_t);
  endfunction
endpackage

// File: rtl/rename_entry.sv
module rename_entry
  import rename_pkg::*;
#(
  parameter int             IDX  = 0,
  parameter logic [DW-1:0]  INIT = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic [TW-1:0] iss_tag,
  input  logic [IW-1:0] iss_dst,
  input  logic          bus_valid,
  input  logic [TW-1:0] bus_tag,
  input  logic [DW-1:0] bus_data,
  output logic [TW-1:0] tag_q,
  output logic [DW-1:0] val_q,
  output logic          wb,
  output logic          claim
);
  assign wb    = tag_hit(bus_valid, bus_tag, tag_q);
  assign claim = iss_valid && (iss_tag != '0) && (iss_dst == IW'(IDX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q <= '0;
      val_q <= INIT;
    end else begin
      if (wb) val_q <= bus_data;
      if (claim)   tag_q <= iss_tag;
      else if (wb) tag_q <= '0;
    end
  end
endmodule

// File: rtl/rename_src_port.sv
module rename_src_port
  import rename_pkg::*;
(
  input  logic [IW-1:0]            sel,
  input  logic [NREG-1:0][TW-1:0]  tag_all,
  input  logic [NREG-1:0][DW-1:0]  val_all,
  input  logic                     bus_valid,
  input  logic [TW-1:0]            bus_tag,
  input  logic [DW-1:0]            bus_data,
  output logic                     pend,
  output logic [TW-1:0]            tag,
  output logic [DW-1:0]            value
);
  logic [TW-1:0] cur_tag;
  logic          fwd;

  assign cur_tag = tag_all[sel];
  assign fwd     = tag_hit(bus_valid, bus_tag, cur_tag);

  always_comb begin
    pend  = 1'b0;
    tag   = '0;
    value = '0;
    if (cur_tag == '0) begin
      value = val_all[sel];
    end else if (fwd) begin
      value = bus_data;
    end else begin
      pend = 1'b1;
      tag  = cur_tag;
    end
  end
endmodule

// File: rtl/rename_table.sv
module rename_table
  import rename_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic [3:0]    iss_tag,
  input  logic [3:0]    iss_dst,
  input  logic [3:0]    iss_src_a,
  input  logic [3:0]    iss_src_b,
  input  logic          bus_valid,
  input  logic [3:0]    bus_tag,
  input  logic [63:0]   bus_data,
  output logic          a_pend,
  output logic [3:0]    a_tag,
  output logic [63:0]   a_val,
  output logic          b_pend,
  output logic [3:0]    b_tag,
  output logic [63:0]   b_val
);
  logic [NREG-1:0][TW-1:0] tag_all;
  logic [NREG-1:0][DW-1:0] val_all;
  logic [NREG-1:0]         entry_wb;
  logic [NREG-1:0]         entry_claim;

  for (genvar k = 0; k < NREG; k++) begin : g_ent
    rename_entry #(.IDX(k), .INIT(init_value(k))) u_ent (
      .clk(clk), .rst_n(rst_n),
      .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_dst(iss_dst),
      .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
      .tag_q(tag_all[k]), .val_q(val_all[k]),
      .wb(entry_wb[k]), .claim(entry_claim[k])
    );
  end

  rename_src_port u_src_a (
    .sel(iss_src_a), .tag_all(tag_all), .val_all(val_all),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
    .pend(a_pend), .tag(a_tag), .value(a_val)
  );

  rename_src_port u_src_b (
    .sel(iss_src_b), .tag_all(tag_all), .val_all(val_all),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
    .pend(b_pend), .tag(b_tag), .value(b_val)
  );
endmodule

// File: rtl/rename_table_chk.sv
module rename_table_chk
  import rename_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     iss_valid,
  input logic [TW-1:0]            iss_tag,
  input logic                     a_pend,
  input logic [TW-1:0]            a_tag,
  input logic [DW-1:0]            a_val,
  input logic                     b_pend,
  input logic [TW-1:0]            b_tag,
  input logic [NREG-1:0][TW-1:0]  tag_all,
  input logic [NREG-1:0][DW-1:0]  val_all,
  input logic [NREG-1:0]          entry_wb,
  input logic [NREG-1:0]          entry_claim
);
  a_r3_pending_has_tag: assert property (@(posedge clk) disable iff (!rst_n)
    a_pend |-> (a_tag != '0) && (a_val == '0));
  a_r2_ready_no_tag: assert property (@(posedge clk) disable iff (!rst_n)
    !a_pend |-> (a_tag == '0));
  a_r2_ready_no_tag_b: assert property (@(posedge clk) disable iff (!rst_n)
    !b_pend |-> (b_tag == '0));
  a_r9_claim_needs_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_claim != '0) |-> iss_valid && (iss_tag != '0) && $onehot0(entry_claim));

  for (genvar k = 0; k < NREG; k++) begin : g_chk
    a_r4_claim_sets_tag: assert property (@(posedge clk) disable iff (!rst_n)
      entry_claim[k] |=> tag_all[k] == $past(iss_tag));
    a_r5_wb_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_wb[k] && !entry_claim[k]) |=> tag_all[k] == '0);
    a_r6_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!entry_wb[k] && !entry_claim[k]) |=> $stable(tag_all[k]) && $stable(val_all[k]));
  end
endmodule

bind rename_table rename_table_chk u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_tag(iss_tag),
  .a_pend(a_pend), .a_tag(a_tag), .a_val(a_val),
  .b_pend(b_pend), .b_tag(b_tag),
  .tag_all(tag_all), .val_all(val_all),
  .entry_wb(entry_wb), .entry_claim(entry_claim)
);

// File: tb/sim_rename_table.sv
`timescale 1ns/1ps
module sim_rename_table;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic [3:0]  iss_tag = '0, iss_dst = '0, iss_src_a = '0, iss_src_b = '0;
  logic        bus_valid = 1'b0;
  logic [3:0]  bus_tag = '0;
  logic [63:0] bus_data = '0;
  logic        a_pend, b_pend;
  logic [3:0]  a_tag, b_tag;
  logic [63:0] a_val, b_val;

  int total = 0, bad = 0;
  logic [3:0]  m_tag [16];
  logic [63:0] m_val [16];

  always #4 clk = ~clk;

  rename_table u0 (.*);

  function automatic logic [63:0] reset_val(input int k);
    return {4{16'(k + 1)}};
  endfunction

  task automatic check_src(input string lbl, input string req, input logic [3:0] s,
                           input logic pend, input logic [3:0] tg, input logic [63:0] v);
    logic        ep;
    logic [3:0]  et;
    logic [63:0] ev;
    string       r;
    ep = 1'b0; et = '0; ev = '0;
    if (m_tag[s] == 0) begin ev = m_val[s]; r = "R2"; end
    else if (bus_valid && bus_tag != 0 && bus_tag == m_tag[s]) begin ev = bus_data; r = "R8"; end
    else begin ep = 1'b1; et = m_tag[s]; r = "R3"; end
    if (req != "") r = req;
    total++;
    if (pend !== ep || tg !== et || v !== ev) begin
      bad++;
      $display("FAIL %s %s reg%0d: got pend=%b tag=%0d val=%h expected pend=%b tag=%0d val=%h",
               r, lbl, s, pend, tg, v, ep, et, ev);
    end
  endtask

  // Drive at falling edge, check the combinational reads, advance model, take the rising edge.
  task automatic step(input string req, input logic iv, input logic [3:0] it, input logic [3:0] id,
                      input logic [3:0] sa, input logic [3:0] sb,
                      input logic bv, input logic [3:0] bt, input logic [63:0] bd);
    @(negedge clk);
    iss_valid = iv; iss_tag = it; iss_dst = id; iss_src_a = sa; iss_src_b = sb;
    bus_valid = bv; bus_tag = bt; bus_data = bd;
    #1;
    check_src("a", req, sa, a_pend, a_tag, a_val);
    check_src("b", req, sb, b_pend, b_tag, b_val);
    for (int k = 0; k < 16; k++) begin
      logic hit, own;
      hit = bv && bt != 0 && m_tag[k] == bt;
      own = iv && it != 0 && id == 4'(k);
      if (hit) m_val[k] = bd;
      if (own) m_tag[k] = it;
      else if (hit) m_tag[k] = '0;
    end
    @(posedge clk);
  endtask

  task automatic probe(input string req, input logic [3:0] sa, input logic [3:0] sb);
    step(req, 1'b0, 4'd0, 4'd0, sa, sb, 1'b0, 4'd0, 64'd0);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20241));
    for (int k = 0; k < 16; k++) begin m_tag[k] = '0; m_val[k] = reset_val(k); end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset contents visible on both ports
    for (int k = 0; k < 16; k += 2) probe("R1", 4'(k), 4'(k + 1));

    // R4: claim then reclaim by a younger writer
    step("R4", 1'b1, 4'd5, 4'd3, 4'd0, 4'd1, 1'b0, 4'd0, 64'd0);
    step("R4", 1'b1, 4'd7, 4'd3, 4'd3, 4'd2, 1'b0, 4'd0, 64'd0);
    probe("R4", 4'd3, 4'd3);
    // R6: the superseded writer broadcasts, register untouched
    step("R6", 1'b0, 4'd0, 4'd0, 4'd0, 4'd1, 1'b1, 4'd5, 64'hDEAD_0000_0000_0005);
    probe("R6", 4'd3, 4'd0);
    // R5: current writer broadcasts to two registers with the same tag
    step("R5", 1'b1, 4'd7, 4'd9, 4'd0, 4'd1, 1'b0, 4'd0, 64'd0);
    step("R5", 1'b0, 4'd0, 4'd0, 4'd4, 4'd5, 1'b1, 4'd7, 64'h1234_5678_9ABC_DEF0);
    probe("R5", 4'd3, 4'd9);
    // R7: issue and matching broadcast on the same register
    step("R7", 1'b1, 4'd2, 4'd4, 4'd0, 4'd1, 1'b0, 4'd0, 64'd0);
    step("R7", 1'b1, 4'd9, 4'd4, 4'd0, 4'd1, 1'b1, 4'd2, 64'hAAAA_BBBB_CCCC_DDDD);
    probe("R7", 4'd4, 4'd4);
    // R8: read of a pending source during its own broadcast
    step("R8", 1'b0, 4'd0, 4'd0, 4'd4, 4'd0, 1'b1, 4'd9, 64'h0F0F_0F0F_F0F0_F0F0);
    probe("R8", 4'd4, 4'd0);
    // R9: zero tags and deasserted valids change nothing
    step("R9", 1'b1, 4'd0, 4'd5, 4'd5, 4'd6, 1'b0, 4'd0, 64'd0);
    step("R9", 1'b0, 4'd6, 4'd5, 4'd5, 4'd6, 1'b1, 4'd0, 64'h5555_5555_5555_5555);
    step("R9", 1'b1, 4'd3, 4'd6, 4'd6, 4'd5, 1'b0, 4'd0, 64'd0);
    step("R9", 1'b0, 4'd0, 4'd0, 4'd6, 4'd5, 1'b0, 4'd3, 64'h7777_7777_7777_7777);
    probe("R9", 4'd6, 4'd5);

    // Random mix: small tag pool, broadcasts usually target a pending tag
    for (int n = 0; n < 3000; n++) begin
      logic [3:0]  it, bt;
      logic [63:0] bd;
      it = 4'($urandom_range(0, 6));
      bt = 4'($urandom_range(0, 6));
      if ($urandom_range(0, 3) != 0) bt = m_tag[$urandom_range(0, 15)];
      bd = {$urandom, $urandom};
      step("", 1'($urandom_range(0, 1)), it, 4'($urandom_range(0, 15)),
           4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
           1'($urandom_range(0, 2) != 0), bt, bd);
    end
    for (int k = 0; k < 16; k += 2) probe("", 4'(k), 4'(k + 1));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule